// File: doc/BRIEF.md
# Privilege Level Transition Controller

This block keeps the privilege state of one processing element: a level from 0 (least privileged) to 3 (most privileged), a width flag that tells whether the element runs in 32-bit or 64-bit mode, and a secure flag. Exception entry requests name a target level, the width the handler will use and the program counter to come back to. Exception return requests need no arguments. Each accepted request updates the state in one clock cycle. Requests that would break the ordering, width or security rules are refused. A refused request leaves every register as it was and raises an error pulse.

Every implemented level owns a bank with a link register and a saved-status register. Entry fills the bank of the target level. Return restores the state from the bank of the current level and presents the banked address as the resume address. While a handler runs, software may overwrite the bank of the current level, and a later return uses whatever the bank holds at that moment. Levels 2 and 3 are build options. When level 3 is left out, the secure flag is taken from a configuration pin during reset and stays fixed.

Top module: `priv_level_ctrl`

## Requirements
- R1: Reset sets the level to the highest implemented level and the width flag to 64-bit. The secure flag is 1 when level 3 is present and takes the value of `cfg_secure` otherwise. Every link and saved-status bank is cleared to zero.
- R2: An entry to an implemented level that is equal to or above the current level is accepted. One cycle later the level equals the target and the width equals `ent_wide`. The target bank's link register holds `ent_pc`. Its status register holds the previous state packed as bit 3 = secure, bit 2 = width (1 = 64-bit), bits 1:0 = level.
- R3: An entry that targets a level below the current one, or a level that is not implemented, is rejected.
- R4: A return loads level, width and secure flag from the current level's status bank. The cycle after the request, `resume_pc` equals the link bank and `resume_vld` is high for one cycle.
- R5: A return whose saved level is above the current level, or is not implemented, is rejected.
- R6: Entry may keep the width or change it from 32-bit to 64-bit. Return may keep the width or change it from 64-bit to 32-bit. When the level stays the same, the width must stay the same. Any other transition is rejected.
- R7: Level 3 always runs in 64-bit mode. An entry or return that would put level 3 in 32-bit mode is rejected.
- R8: With level 3 present, the secure flag is 1 exactly when the level is 3, and a return whose saved secure bit disagrees with its saved level is rejected. Without level 3, the secure flag never changes after reset, and a return whose saved secure bit differs from it is rejected.
- R9: `sw_link_we` writes `sw_data` into the current level's link bank. `sw_stat_we` writes `sw_data[3:0]` into the current level's status bank. Both writes take effect at the next edge and are dropped in any cycle that carries an entry or a return request.
- R10: A rejected request, including one that asserts entry and return together, changes no state and no bank. `illegal` goes high for one cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_secure | input | 1 | Secure state loaded during reset when level 3 is absent |
| ent_req | input | 1 | Exception entry request |
| ent_lvl | input | 2 | Target level of the entry |
| ent_wide | input | 1 | Handler width, 1 = 64-bit |
| ent_pc | input | AW | Address to bank as the return address |
| ret_req | input | 1 | Exception return request |
| sw_link_we | input | 1 | Software write to the current link bank |
| sw_stat_we | input | 1 | Software write to the current status bank |
| sw_data | input | AW | Data for software bank writes |
| cur_lvl | output | 2 | Current privilege level |
| cur_wide | output | 1 | Current width, 1 = 64-bit |
| cur_secure | output | 1 | Current secure flag |
| resume_pc | output | AW | Address restored by the last accepted return |
| resume_vld | output | 1 | One-cycle pulse after an accepted return |
| illegal | output | 1 | One-cycle pulse after a rejected request |

## Verification
The controller registers every result once. Level, width, secure flag, `resume_pc`, `resume_vld` and `illegal` all appear one edge after the request cycle, and a bank write shows up only when a later return reads it. The bench drives each vector on a falling edge and holds it for one cycle. It clears the request on the next falling edge and compares the outputs right then, so the sample falls exactly one edge after the request and never on the edge itself. Software bank writes are checked indirectly, through the address and state that a following return brings out.

// File: rtl/priv_level_pkg.sv
package priv_level_pkg;

  localparam int LVL_W = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // packed saved-status word: {secure, wide, level}
  typedef struct packed {
    logic sec;
    logic wide;
    lvl_t lvl;
  } pstat_t;

  localparam int STAT_W = $bits(pstat_t);

  function automatic logic lvl_present(lvl_t l, logic has2, logic has3);
    return (l < 2'd2) || (l == 2'd2 && has2) || (l == 2'd3 && has3);
  endfunction

  function automatic lvl_t top_level(logic has2, logic has3);
    if (has3) return 2'd3;
    if (has2) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic entry_legal(pstat_t cur, lvl_t tgt, logic tgt_wide,
                                       logic has2, logic has3);
    if (!lvl_present(tgt, has2, has3)) return 1'b0;
    if (tgt < cur.lvl) return 1'b0;
    if (tgt == 2'd3 && !tgt_wide) return 1'b0;
    if (tgt == cur.lvl) return tgt_wide == cur.wide;
    return !(cur.wide && !tgt_wide);
  endfunction

  function automatic logic sec_legal(pstat_t cur, pstat_t sv, logic has3);
    if (has3) return sv.sec == (sv.lvl == 2'd3);
    return sv.sec == cur.sec;
  endfunction

  function automatic logic return_legal(pstat_t cur, pstat_t sv,
                                        logic has2, logic has3);
    if (!lvl_present(sv.lvl, has2, has3)) return 1'b0;
    if (sv.lvl > cur.lvl) return 1'b0;
    if (sv.lvl == 2'd3 && !sv.wide) return 1'b0;
    if (!sec_legal(cur, sv, has3)) return 1'b0;
    if (sv.lvl == cur.lvl) return sv.wide == cur.wide;
    return !(!cur.wide && sv.wide);
  endfunction

endpackage

// File: rtl/priv_level_judge.sv
module priv_level_judge
  import priv_level_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  pstat_t cur,
  input  logic   ent_req,
  input  lvl_t   ent_lvl,
  input  logic   ent_wide,
  input  logic   ret_req,
  input  pstat_t saved,
  output logic   ent_go,
  output logic   ret_go,
  output logic   reject,
  output logic   sw_go
);

  logic both_req;
  logic ent_ok;
  logic ret_ok;

  assign both_req = ent_req && ret_req;
  assign ent_ok   = entry_legal(cur, ent_lvl, ent_wide, HAS_L2, HAS_L3);
  assign ret_ok   = return_legal(cur, saved, HAS_L2, HAS_L3);

  assign ent_go = ent_req && !both_req && ent_ok;
  assign ret_go = ret_req && !both_req && ret_ok;
  assign reject = (ent_req || ret_req) && !ent_go && !ret_go;
  assign sw_go  = !ent_req && !ret_req;

endmodule

// File: rtl/priv_level_bank.sv
module priv_level_bank
  import priv_level_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_go,
  input  lvl_t          ent_lvl,
  input  logic [AW-1:0] ent_pc,
  input  pstat_t        ent_stat,
  input  logic          sw_go,
  input  logic          sw_link_we,
  input  logic          sw_stat_we,
  input  logic [AW-1:0] sw_data,
  input  lvl_t          cur_lvl,
  output logic [AW-1:0] rd_link,
  output pstat_t        rd_stat
);

  localparam int NLVL = 1 << LVL_W;

  logic [AW-1:0] link_q [NLVL];
  pstat_t        stat_q [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam lvl_t MY_LVL = lvl_t'(g);
    if (lvl_present(MY_LVL, HAS_L2, HAS_L3)) begin : g_on
      logic hit_ent;
      logic hit_sw;
      assign hit_ent = ent_go && (ent_lvl == MY_LVL);
      assign hit_sw  = sw_go && (cur_lvl == MY_LVL);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          link_q[g] <= '0;
          stat_q[g] <= '0;
        end else if (hit_ent) begin
          link_q[g] <= ent_pc;
          stat_q[g] <= ent_stat;
        end else if (hit_sw) begin
          if (sw_link_we) link_q[g] <= sw_data;
          if (sw_stat_we) stat_q[g] <= pstat_t'(sw_data[STAT_W-1:0]);
        end
      end
    end else begin : g_off
      assign link_q[g] = '0;
      assign stat_q[g] = '0;
    end
  end

  assign rd_link = link_q[cur_lvl];
  assign rd_stat = stat_q[cur_lvl];

endmodule

// File: rtl/priv_level_state.sv
module priv_level_state
  import priv_level_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_secure,
  input  logic          ent_go,
  input  lvl_t          ent_lvl,
  input  logic          ent_wide,
  input  logic          ret_go,
  input  logic          reject,
  input  pstat_t        saved,
  input  logic [AW-1:0] saved_link,
  output pstat_t        cur,
  output logic [AW-1:0] resume_pc,
  output logic          resume_vld,
  output logic          illegal
);

  localparam lvl_t RST_LVL = top_level(HAS_L2, HAS_L3);

  pstat_t cur_q;
  logic   ent_sec;

  assign ent_sec = HAS_L3 ? (ent_lvl == 2'd3) : cur_q.sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q.lvl  <= RST_LVL;
      cur_q.wide <= 1'b1;
      cur_q.sec  <= HAS_L3 ? 1'b1 : cfg_secure;
      resume_pc  <= '0;
      resume_vld <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      resume_vld <= ret_go;
      illegal    <= reject;
      if (ent_go) begin
        cur_q.lvl  <= ent_lvl;
        cur_q.wide <= ent_wide;
        cur_q.sec  <= ent_sec;
      end else if (ret_go) begin
        cur_q     <= saved;
        resume_pc <= saved_link;
      end
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/priv_level_ctrl.sv
module priv_level_ctrl
  import priv_level_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_secure,
  input  logic          ent_req,
  input  logic [1:0]    ent_lvl,
  input  logic          ent_wide,
  input  logic [AW-1:0] ent_pc,
  input  logic          ret_req,
  input  logic          sw_link_we,
  input  logic          sw_stat_we,
  input  logic [AW-1:0] sw_data,
  output logic [1:0]    cur_lvl,
  output logic          cur_wide,
  output logic          cur_secure,
  output logic [AW-1:0] resume_pc,
  output logic          resume_vld,
  output logic          illegal
);

  pstat_t        cur;
  pstat_t        saved;
  logic [AW-1:0] saved_link;
  logic          ent_go;
  logic          ret_go;
  logic          reject;
  logic          sw_go;

  priv_level_judge #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_judge (
    .cur      (cur),
    .ent_req  (ent_req),
    .ent_lvl  (ent_lvl),
    .ent_wide (ent_wide),
    .ret_req  (ret_req),
    .saved    (saved),
    .ent_go   (ent_go),
    .ret_go   (ret_go),
    .reject   (reject),
    .sw_go    (sw_go)
  );

  priv_level_bank #(.AW(AW), .HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_go     (ent_go),
    .ent_lvl    (ent_lvl),
    .ent_pc     (ent_pc),
    .ent_stat   (cur),
    .sw_go      (sw_go),
    .sw_link_we (sw_link_we),
    .sw_stat_we (sw_stat_we),
    .sw_data    (sw_data),
    .cur_lvl    (cur.lvl),
    .rd_link    (saved_link),
    .rd_stat    (saved)
  );

  priv_level_state #(.AW(AW), .HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_secure (cfg_secure),
    .ent_go     (ent_go),
    .ent_lvl    (ent_lvl),
    .ent_wide   (ent_wide),
    .ret_go     (ret_go),
    .reject     (reject),
    .saved      (saved),
    .saved_link (saved_link),
    .cur        (cur),
    .resume_pc  (resume_pc),
    .resume_vld (resume_vld),
    .illegal    (illegal)
  );

  assign cur_lvl    = cur.lvl;
  assign cur_wide   = cur.wide;
  assign cur_secure = cur.sec;

endmodule

// File: rtl/priv_level_sva.sv
module priv_level_sva #(
  parameter bit HAS_L3 = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ent_go,
  input logic       ret_go,
  input logic [1:0] lvl,
  input logic       wide,
  input logic       sec,
  input logic       illegal,
  input logic       resume_vld
);

  // R3
  entry_not_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_go |=> (lvl >= $past(lvl)));

  // R5
  return_not_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> (lvl <= $past(lvl)));

  // R6
  width_same_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_go || ret_go) && !illegal |=> ((lvl == $past(lvl)) ? (wide == $past(wide)) : 1'b1));

  // R6
  width_up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_go |=> !($past(wide) && !wide));

  // R6
  width_down_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> !(!$past(wide) && wide));

  // R7
  top_level_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd3) |-> wide);

  // R8
  secure_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_L3 |-> (sec == (lvl == 2'd3)));

  // R10
  reject_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(lvl) && $stable(wide) && $stable(sec)));

  // R4
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && resume_vld));

endmodule

bind priv_level_ctrl priv_level_sva #(.HAS_L3(HAS_L3)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ent_go     (ent_go),
  .ret_go     (ret_go),
  .lvl        (cur_lvl),
  .wide       (cur_wide),
  .sec        (cur_secure),
  .illegal    (illegal),
  .resume_vld (resume_vld)
);

// File: tb/priv_level_ctrl_tb.sv
module priv_level_ctrl_tb;

  localparam int AW = 32;
  localparam int VW = 44;

  // op: 0 idle, 1 entry, 2 return, 3 sw link, 4 sw status, 5 entry+return, 6 entry+sw link
  function automatic logic [VW-1:0] v(int op, int tl, int tw, int dat,
                                      int el, int ew, int es, int ei, int erv, int epc);
    return {3'(op), 2'(tl), 1'(tw), 16'(dat), 2'(el), 1'(ew), 1'(es), 1'(ei), 1'(erv), 16'(epc)};
  endfunction

  localparam int NV = 28;
  localparam logic [VW-1:0] VECS [NV] = '{
    v(1,3,1,'h0100, 3,1,1,0,0,'h0000),  // R2 same level entry
    v(2,0,0,'h0000, 3,1,1,0,1,'h0100),  // R4
    v(4,0,0,'h0000, 3,1,1,0,0,'h0000),  // R9 status := lvl0/32/nonsec
    v(3,0,0,'h0400, 3,1,1,0,0,'h0000),  // R9
    v(2,0,0,'h0000, 0,0,0,0,1,'h0400),  // R4 R6 R8 return 64->32
    v(1,1,1,'h0500, 1,1,0,0,0,'h0000),  // R2 R6 entry 32->64
    v(1,0,1,'h0510, 1,1,0,1,0,'h0000),  // R3 lower target
    v(1,2,0,'h0520, 1,1,0,1,0,'h0000),  // R6 entry 64->32
    v(1,2,1,'h0600, 2,1,0,0,0,'h0000),  // R2
    v(1,3,1,'h0700, 3,1,1,0,0,'h0000),  // R2 R8
    v(2,0,0,'h0000, 2,1,0,0,1,'h0700),  // R4 status {0,1,2}
    v(4,0,0,'h0007, 2,1,0,0,0,'h0000),  // R9
    v(2,0,0,'h0000, 2,1,0,1,0,'h0000),  // R5 raise to 3
    v(4,0,0,'h000D, 2,1,0,0,0,'h0000),  // R9
    v(2,0,0,'h0000, 2,1,0,1,0,'h0000),  // R8 secure mismatch
    v(4,0,0,'h0001, 2,1,0,0,0,'h0000),  // R9
    v(3,0,0,'h0880, 2,1,0,0,0,'h0000),  // R9
    v(2,0,0,'h0000, 1,0,0,0,1,'h0880),  // R4
    v(4,0,0,'h0004, 1,0,0,0,0,'h0000),  // R9 lvl0 64-bit
    v(2,0,0,'h0000, 1,0,0,1,0,'h0000),  // R6 return 32->64
    v(4,0,0,'h0000, 1,0,0,0,0,'h0000),  // R9
    v(1,1,1,'h0A00, 1,0,0,1,0,'h0000),  // R6 same level width change
    v(1,3,0,'h0A10, 1,0,0,1,0,'h0000),  // R7 level 3 in 32-bit
    v(5,2,1,'h0A20, 1,0,0,1,0,'h0000),  // R10 both requests
    v(2,0,0,'h0000, 0,0,0,0,1,'h0500),  // R10 R4 bank1 untouched
    v(6,1,1,'h0900, 1,1,0,0,0,'h0000),  // R9 sw write dropped
    v(2,0,0,'h0000, 0,0,0,0,1,'h0900),  // R4
    v(2,0,0,'h0000, 0,0,0,0,1,'h0000)   // R9 bank0 link still 0
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ent_req = 1'b0, ent_wide = 1'b0, ret_req = 1'b0;
  logic          sw_link_we = 1'b0, sw_stat_we = 1'b0;
  logic [1:0]    ent_lvl = '0;
  logic [AW-1:0] ent_pc = '0, sw_data = '0;
  logic [1:0]    cur_lvl;
  logic          cur_wide, cur_secure, resume_vld, illegal;
  logic [AW-1:0] resume_pc;

  logic          m_ent_req = 1'b0, m_ent_wide = 1'b0, m_ret_req = 1'b0, m_stat_we = 1'b0;
  logic [1:0]    m_ent_lvl = '0;
  logic [AW-1:0] m_pc = '0, m_data = '0;
  logic [1:0]    m_lvl;
  logic          m_wide, m_sec, m_rvld, m_ill;
  logic [AW-1:0] m_rpc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  priv_level_ctrl #(.AW(AW), .HAS_L2(1'b1), .HAS_L3(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_secure(1'b0),
    .ent_req(ent_req), .ent_lvl(ent_lvl), .ent_wide(ent_wide), .ent_pc(ent_pc),
    .ret_req(ret_req), .sw_link_we(sw_link_we), .sw_stat_we(sw_stat_we), .sw_data(sw_data),
    .cur_lvl(cur_lvl), .cur_wide(cur_wide), .cur_secure(cur_secure),
    .resume_pc(resume_pc), .resume_vld(resume_vld), .illegal(illegal)
  );

  priv_level_ctrl #(.AW(AW), .HAS_L2(1'b0), .HAS_L3(1'b0)) u_dut_min (
    .clk(clk), .rst_n(rst_n), .cfg_secure(1'b1),
    .ent_req(m_ent_req), .ent_lvl(m_ent_lvl), .ent_wide(m_ent_wide), .ent_pc(m_pc),
    .ret_req(m_ret_req), .sw_link_we(1'b0), .sw_stat_we(m_stat_we), .sw_data(m_data),
    .cur_lvl(m_lvl), .cur_wide(m_wide), .cur_secure(m_sec),
    .resume_pc(m_rpc), .resume_vld(m_rvld), .illegal(m_ill)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(int idx, logic [VW-1:0] vec);
    logic [2:0] op;
    op = vec[43:41];
    @(negedge clk);
    ent_lvl  = vec[40:39];
    ent_wide = vec[38];
    ent_pc   = AW'(vec[37:22]);
    sw_data  = (op == 3'd6) ? AW'(32'h0ABC) : AW'(vec[37:22]);
    ent_req    = (op == 3'd1) || (op == 3'd5) || (op == 3'd6);
    ret_req    = (op == 3'd2) || (op == 3'd5);
    sw_link_we = (op == 3'd3) || (op == 3'd6);
    sw_stat_we = (op == 3'd4);
    @(negedge clk);
    ent_req = 1'b0; ret_req = 1'b0; sw_link_we = 1'b0; sw_stat_we = 1'b0;
    check($sformatf("R2 R4 vec%0d level", idx), 32'(cur_lvl), 32'(vec[21:20]));
    check($sformatf("R6 vec%0d width", idx), 32'(cur_wide), 32'(vec[19]));
    check($sformatf("R8 vec%0d secure", idx), 32'(cur_secure), 32'(vec[18]));
    check($sformatf("R10 vec%0d illegal", idx), 32'(illegal), 32'(vec[17]));
    check($sformatf("R4 vec%0d resume_vld", idx), 32'(resume_vld), 32'(vec[16]));
    if (vec[16]) check($sformatf("R4 vec%0d resume_pc", idx), resume_pc, 32'(vec[15:0]));
  endtask

  task automatic m_step(logic e, logic [1:0] l, logic w, logic [31:0] pc,
                        logic r, logic swe, logic [31:0] d);
    @(negedge clk);
    m_ent_req = e; m_ent_lvl = l; m_ent_wide = w; m_pc = pc;
    m_ret_req = r; m_stat_we = swe; m_data = d;
    @(negedge clk);
    m_ent_req = 1'b0; m_ret_req = 1'b0; m_stat_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, full configuration
    check("R1 reset level", 32'(cur_lvl), 32'd3);
    check("R1 reset width", 32'(cur_wide), 32'd1);
    check("R1 reset secure", 32'(cur_secure), 32'd1);
    check("R1 reset illegal", 32'(illegal), 32'd0);
    check("R1 reset resume_vld", 32'(resume_vld), 32'd0);
    // R1 reset state, minimal configuration (levels 0..1, secure from pin)
    check("R1 min reset level", 32'(m_lvl), 32'd1);
    check("R1 min reset width", 32'(m_wide), 32'd1);
    check("R1 min reset secure", 32'(m_sec), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R3 entry to absent level 2
    m_step(1'b1, 2'd2, 1'b1, 32'h10, 1'b0, 1'b0, 32'h0);
    check("R3 min absent l2 illegal", 32'(m_ill), 32'd1);
    check("R3 min absent l2 level", 32'(m_lvl), 32'd1);
    // R3 entry to absent level 3
    m_step(1'b1, 2'd3, 1'b1, 32'h20, 1'b0, 1'b0, 32'h0);
    check("R3 min absent l3 illegal", 32'(m_ill), 32'd1);
    // R8 cleared status has secure 0, differs from fixed secure 1
    m_step(1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
    check("R8 min secure mismatch illegal", 32'(m_ill), 32'd1);
    check("R8 min secure kept", 32'(m_sec), 32'd1);
    // R9 status := secure=1, 32-bit, level 0
    m_step(1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 32'h8);
    m_step(1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
    check("R4 min return valid", 32'(m_rvld), 32'd1);
    check("R1 min cleared link", m_rpc, 32'h0);
    check("R4 min level", 32'(m_lvl), 32'd0);
    check("R6 min width", 32'(m_wide), 32'd0);
    check("R8 min secure fixed", 32'(m_sec), 32'd1);
    // R2 R8 entry keeps fixed secure state
    m_step(1'b1, 2'd1, 1'b1, 32'h40, 1'b0, 1'b0, 32'h0);
    check("R2 min entry level", 32'(m_lvl), 32'd1);
    check("R8 min entry secure", 32'(m_sec), 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule